// File: doc/BRIEF.md
# Tap-Selectable Operand Delay Stack

This block delays one signed operand word by a run-time programmable number of clocks before it reaches a multiplier. Every clock, the incoming word is captured in an input register. Behind that register sits a stack of `DEPTH` stages, sixteen by default, and it only advances when the active-low push control is asserted. When it advances, the input register's contents enter the newest stage and every older entry moves one stage deeper. When push is deasserted, the stack stays frozen and the word currently held in the input register is lost.

A select code is registered every clock and picks which stage drives the operand output. That output is registered too, so the multiplier sees a clean pipeline stage. Code 0 picks the newest stage and code `DEPTH-1` picks the oldest, which gives one to sixteen pushes of delay at the default depth. A chip that needs several operands uses one instance per operand, and each instance has its own push control and select code. A synchronous active-high reset clears every register, so the stack starts from a known state instead of holding unknown contents.

Top module: `opd_delay_stack`

## Requirements
- R1: The input register loads `din` on every rising clock edge, whatever the value of `push_n`.
- R2: At an edge where `push_n` is 0, stage 0 takes the input register's previous value and each stage i>0 takes the previous value of stage i-1.
- R3: At an edge where `push_n` is 1, no stack stage changes and the word held in the input register is never stored, so it can never reach `opnd`.
- R4: With `push_n` held at 0 and the select code held at s, a word sampled on `din` at edge n appears on `opnd` right after edge n+s+2. That is one edge for capture, s+1 pushes to reach stage s, and one edge for the output register.
- R5: Select code s routes stage s to `opnd`, where code 0 is the newest stage and code `DEPTH-1` (binary 1111 at the default depth) is the oldest. The code is registered: a value sampled at edge k governs `opnd` from edge k+1 onward.
- R6: While the stack is frozen, changing the select code re-reads different stages of the frozen contents without disturbing them.
- R7: At an edge where `rst` is 1, the input register, every stack stage, the registered select and `opnd` all become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Operand word, two's complement |
| push_n | input | 1 | Active-low stack advance |
| tap_sel | input | $clog2(DEPTH) | Stage select code |
| opnd | output | DATA_W | Registered delayed operand |

## Verification
A corrupted stage, or a shift that happens on the wrong edge, shows up on `opnd` as soon as the select code points at the damaged stage. Under continuous pushing it also shows up when the bad word drifts to the selected depth, which takes at most `DEPTH+1` clocks. A stack that advances while stalled shows up one clock later, as an output that changes when it should have stayed constant. A select path with the wrong latency shows up within two clocks of any change of code. The random phases therefore sweep the select code and interleave stalls, so that every stage is read soon after each write.

// File: rtl/opd_pkg.sv
package opd_pkg;

    localparam int OPD_DATA_W_DEF = 12;
    localparam int OPD_DEPTH_DEF  = 16;

    // Map a select code onto a legal stage index; codes past the last stage
    // read the oldest stage when DEPTH is not a power of two.
    function automatic int opd_tap_index(input int code, input int depth);
        if (code >= depth) begin
            return depth - 1;
        end
        return code;
    endfunction

    // Stack action decoded from the active-low push control.
    typedef enum logic {
        STK_HOLD = 1'b0,
        STK_PUSH = 1'b1
    } stk_op_e;

    function automatic stk_op_e opd_decode_push(input logic push_n);
        return push_n ? STK_HOLD : STK_PUSH;
    endfunction

endpackage

// File: rtl/opd_in_reg.sv
module opd_in_reg #(
    parameter int DATA_W = opd_pkg::OPD_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/opd_push_stack.sv
module opd_push_stack
    import opd_pkg::*;
#(
    parameter int DATA_W = OPD_DATA_W_DEF,
    parameter int DEPTH  = OPD_DEPTH_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  stk_op_e                      op,
    input  logic [DATA_W-1:0]            top_in,
    output logic [DEPTH-1:0][DATA_W-1:0] stages
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic [DATA_W-1:0] feed;

        if (g == 0) begin : g_head
            assign feed = top_in;
        end else begin : g_body
            assign feed = stages[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stages[g] <= '0;
            end else if (op == STK_PUSH) begin
                stages[g] <= feed;
            end
        end
    end

endmodule

// File: rtl/opd_tap_sel.sv
module opd_tap_sel
    import opd_pkg::*;
#(
    parameter int DATA_W = OPD_DATA_W_DEF,
    parameter int DEPTH  = OPD_DEPTH_DEF,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SEL_W-1:0]             sel_in,
    input  logic [DEPTH-1:0][DATA_W-1:0] stages,
    output logic [SEL_W-1:0]             sel_q,
    output logic [DATA_W-1:0]            tap_q
);

    logic [SEL_W-1:0]  idx;
    logic [DATA_W-1:0] tap_d;

    always_comb begin
        idx   = SEL_W'(opd_tap_index(int'(sel_q), DEPTH));
        tap_d = stages[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            tap_q <= '0;
        end else begin
            sel_q <= sel_in;
            tap_q <= tap_d;
        end
    end

endmodule

// File: rtl/opd_delay_stack.sv
module opd_delay_stack
    import opd_pkg::*;
#(
    parameter int DATA_W = OPD_DATA_W_DEF,
    parameter int DEPTH  = OPD_DEPTH_DEF,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              push_n,
    input  logic [SEL_W-1:0]  tap_sel,
    output logic [DATA_W-1:0] opnd
);

    logic [DATA_W-1:0]            in_q;
    logic [DEPTH-1:0][DATA_W-1:0] stk_q;
    logic [SEL_W-1:0]             sel_q;
    stk_op_e                      stk_op;

    assign stk_op = opd_decode_push(push_n);

    opd_in_reg #(
        .DATA_W(DATA_W)
    ) in_reg_i (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (in_q)
    );

    opd_push_stack #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) stack_i (
        .clk    (clk),
        .rst    (rst),
        .op     (stk_op),
        .top_in (in_q),
        .stages (stk_q)
    );

    opd_tap_sel #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) tap_i (
        .clk    (clk),
        .rst    (rst),
        .sel_in (tap_sel),
        .stages (stk_q),
        .sel_q  (sel_q),
        .tap_q  (opnd)
    );

endmodule

// File: rtl/opd_delay_stack_chk.sv
module opd_delay_stack_chk
    import opd_pkg::*;
#(
    parameter int DATA_W = OPD_DATA_W_DEF,
    parameter int DEPTH  = OPD_DEPTH_DEF,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input logic                         clk,
    input logic                         rst,
    input logic [DATA_W-1:0]            din,
    input logic                         push_n,
    input logic [SEL_W-1:0]             tap_sel,
    input logic [DATA_W-1:0]            opnd,
    input logic [DATA_W-1:0]            in_q,
    input logic [DEPTH-1:0][DATA_W-1:0] stk_q,
    input logic [SEL_W-1:0]             sel_q
);

    logic [SEL_W-1:0] chk_idx;
    assign chk_idx = SEL_W'(opd_tap_index(int'(sel_q), DEPTH));

    // R1: input register loads every clock
    a_r1_capture_always: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> in_q == $past(din));

    // R2: push moves the input register into the head stage
    a_r2_push_head: assert property (@(posedge clk) disable iff (rst)
        !push_n |=> stk_q[0] == $past(in_q));

    // R2: push shifts the deepest stage from its neighbour
    a_r2_push_tail: assert property (@(posedge clk) disable iff (rst)
        !push_n |=> stk_q[DEPTH-1] == $past(stk_q[DEPTH-2]));

    // R3: stalled edge leaves the whole stack untouched
    a_r3_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        push_n |=> $stable(stk_q));

    // R5: registered select follows the code one edge later
    a_r5_sel_registered: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sel_q == $past(tap_sel));

    // R5: output carries the stage chosen by the registered select
    a_r5_tap_route: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> opnd == $past(stk_q[chk_idx]));

    // R7: first cycle after reset shows cleared output and select
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (opnd == '0 && sel_q == '0 && in_q == '0));

endmodule

bind opd_delay_stack opd_delay_stack_chk #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .push_n (push_n),
    .tap_sel(tap_sel),
    .opnd   (opnd),
    .in_q   (in_q),
    .stk_q  (stk_q),
    .sel_q  (sel_q)
);

// File: tb/opd_delay_stack_tb.sv
`timescale 1ns/1ps
module opd_delay_stack_tb_top;

    localparam int DATA_W = 12;
    localparam int DEPTH  = 16;
    localparam int SEL_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst;
    logic [DATA_W-1:0] din;
    logic              push_n;
    logic [SEL_W-1:0]  tap_sel;
    logic [DATA_W-1:0] opnd;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state derived from the requirements
    logic [DATA_W-1:0] m_in;
    logic [DATA_W-1:0] m_stk [DEPTH];
    logic [SEL_W-1:0]  m_sel;
    logic [DATA_W-1:0] m_out;

    always #2 clk = ~clk;

    opd_delay_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .din(din), .push_n(push_n),
        .tap_sel(tap_sel), .opnd(opnd)
    );

    function automatic logic [DATA_W-1:0] exp_tap(input logic [SEL_W-1:0] s);
        return m_stk[int'(s)];
    endfunction

    task automatic check(input string tag, input logic [DATA_W-1:0] got,
                         input logic [DATA_W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: opnd=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive inputs at the falling edge, advance the model at the rising edge,
    // then sample one time unit later.
    task automatic step(input logic r, input logic [DATA_W-1:0] d,
                        input logic pn, input logic [SEL_W-1:0] s);
        @(negedge clk);
        rst = r; din = d; push_n = pn; tap_sel = s;
        @(posedge clk);
        if (r) begin
            m_in = '0; m_sel = '0; m_out = '0;
            for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
        end else begin
            m_out = exp_tap(m_sel);
            if (!pn) begin
                for (int i = DEPTH-1; i > 0; i--) m_stk[i] = m_stk[i-1];
                m_stk[0] = m_in;
            end
            m_in  = d;
            m_sel = s;
        end
        #1;
    endtask

    // R4: latency measured with a marker word under continuous pushing
    task automatic latency_probe(input int s);
        logic [DATA_W-1:0] mark;
        int cnt;
        int seen;
        mark = 12'hA5C;
        for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 12'h000, 1'b0, SEL_W'(s));
        step(1'b0, mark, 1'b0, SEL_W'(s));
        cnt = 0;
        seen = -1;
        while (cnt < DEPTH + 6 && seen < 0) begin
            if (opnd === mark) seen = cnt;
            else begin
                step(1'b0, 12'h000, 1'b0, SEL_W'(s));
                cnt++;
            end
        end
        n_cmp++;
        if (seen != s + 2) begin
            n_bad++;
            $display("FAIL R4: marker latency=%0d expected=%0d (sel=%0d)", seen, s + 2, s);
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; din = '0; push_n = 1'b1; tap_sel = '0;
        for (int i = 0; i < 3; i++) step(1'b1, 12'hFFF, 1'b0, 4'hF);
        check("R7 reset clears output", opnd, 12'h000);

        // R4: shortest and longest delay, plus a middle code
        latency_probe(0);
        latency_probe(DEPTH - 1);
        latency_probe(7);

        // R1 R3: word captured right before a stall must never emerge
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 12'h111, 1'b0, 4'h0);
        step(1'b0, 12'h7E7, 1'b0, 4'h0);
        step(1'b0, 12'h111, 1'b1, 4'h0);
        begin
            int leaks = 0;
            for (int i = 0; i < DEPTH + 4; i++) begin
                step(1'b0, 12'h111, 1'b0, 4'h0);
                if (opnd === 12'h7E7) leaks++;
            end
            n_cmp++;
            if (leaks != 0) begin
                n_bad++;
                $display("FAIL R3: dropped word seen %0d times expected 0", leaks);
            end
        end

        // R2 R6: fill with distinct words, freeze, then sweep the select
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, DATA_W'(i + 32), 1'b0, 4'h0);
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 12'hBAD, 1'b1, SEL_W'(i));
            step(1'b0, 12'hBAD, 1'b1, SEL_W'(i));
            check("R6 frozen stage reread", opnd, exp_tap(SEL_W'(i)));
        end
        // stage 0 newest, stage DEPTH-1 oldest
        step(1'b0, 12'hBAD, 1'b1, 4'h0);
        step(1'b0, 12'hBAD, 1'b1, 4'h0);
        check("R5 code 0 newest stage", opnd, DATA_W'(DEPTH + 31));
        step(1'b0, 12'hBAD, 1'b1, 4'hF);
        check("R5 new code not yet effective", opnd, DATA_W'(DEPTH + 31));
        step(1'b0, 12'hBAD, 1'b1, 4'hF);
        check("R5 code 1111 oldest stage", opnd, DATA_W'(32));

        // R2 R3 R5: random mix of pushes, stalls and code changes
        for (int i = 0; i < 3000; i++) begin
            logic [DATA_W-1:0] d;
            logic pn;
            logic [SEL_W-1:0] s;
            d  = DATA_W'($urandom);
            pn = ($urandom % 4) == 0;
            s  = (($urandom % 8) == 0) ? SEL_W'($urandom) : tap_sel;
            if (i % 500 == 0) s = (i % 1000 == 0) ? 4'h0 : 4'hF;
            step(1'b0, d, pn, s);
            check("R2 random push/hold/select", opnd, m_out);
        end

        // R7: mid-run reset
        step(1'b1, 12'h3C3, 1'b0, 4'h9);
        check("R7 mid-run reset", opnd, 12'h000);
        step(1'b0, 12'h3C3, 1'b1, 4'h9);
        step(1'b0, 12'h3C3, 1'b1, 4'h9);
        check("R7 stack cleared after reset", opnd, 12'h000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule